// File: doc/BRIEF.md
# Nested Vectored Interrupt Priority Resolver

This block sits after an interrupt masking stage. It decides whether the normal interrupt line to the processor should be raised, and it hands the processor the address of the handler to run. Sixteen programmable vector slots each bind to one of 32 interrupt sources and carry a 32-bit handler address. A seventeenth, default address covers any source that no enabled slot claims. A lower slot number means a higher priority.

The block keeps a current service level. At idle the level is 17, and at that level every source is allowed through. A read of the vector register acknowledges an interrupt. The block looks for the highest-priority pending source that beats the current level, moves to that level, remembers the level it came from, and returns the handler address. A write to the same register (the data is ignored) closes the handler and goes back exactly one level. The service tracker is a two-state machine. The state `LV_IDLE` means no handler is open and `LV_SERVICE` means at least one is. Its transitions are T_ENTER (IDLE to SERVICE on an acknowledge that finds a source), T_NEST (SERVICE to SERVICE on a deeper acknowledge), T_UNWIND (SERVICE to SERVICE when a close returns to an outer level), T_RELEASE (SERVICE to IDLE when a close returns to level 17) and T_STAY (any state, no change).

The register bus uses word addresses and a one-cycle select strobe. Read data is registered one cycle after the strobe and is held until the next read. Word 12 is the vector register, word 13 the default address, words 64 to 79 the slot addresses and words 128 to 143 the slot control bytes. Every other word reads as zero and ignores writes.

Top module: `nvpr_core`

## Requirements
- R1: After reset all slot addresses, the default address and all control bytes read 0, and the level is 17 (idle), so `irq_out` is high whenever any `src_irq` bit is high.
- R2: A control byte holds 6 bits. Bit 5 enables the slot and bits 4:0 select the source. Bits 7:6 are not stored and read as 0. Slot addresses and the default address read back as written.
- R3: `irq_out` is the OR over `src_irq & M[L]`, where L is the current level. M[L] is the OR of the one-hot source bits of the enabled slots numbered below L, M[16] covers all 16 slots, and M[17] is all ones.
- R4: A vector-register read at idle, with a source pending in `src_raw` that an enabled slot claims, returns the address of the lowest-numbered such slot and moves the level to that slot.
- R5: A vector-register read at idle returns the default address. If `src_raw` has a pending bit that no enabled slot claims, the level moves to 16; if `src_raw` is zero, the level stays at 17.
- R6: A vector-register read while in service moves to a deeper level only for a pending slot numbered below the current level. Otherwise it returns the current level's address and leaves the level unchanged.
- R7: A vector-register write while in service restores exactly the level that was current before the matching acknowledge. A write at idle has no effect.
- R8: The acknowledge side effect happens once per read strobe. The read data stays unchanged while no further read is made.
- R9: A control-byte write changes the masks used by `irq_out` from the cycle after the write strobe.
- R10: The default address at word 13 is readable and writable, and it is what a vector read returns when R5 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_raw | input | 32 | Raw pending sources (hardware or software), used by the acknowledge search |
| src_irq | input | 32 | Pending sources that are enabled and routed to the normal line |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, held until the next read |
| irq_out | output | 1 | Normal interrupt request |

## Verification
Only the read data and the level have a register on their path, so each of them changes at the clock edge that samples the strobe. The bench raises the strobe on a falling edge, drops it on the next falling edge and reads `bus_rdata` there, half a period after the update. `irq_out` is combinational from `src_irq` and the level register. The bench therefore changes `src_irq` on a falling edge and samples 1 ns later. This shows each level move, such as an acknowledge, a close or an ignored close, in the first half cycle after the strobe's edge. The held-data check waits four idle cycles before it looks at the read data again.

// File: rtl/nvpr_pkg.sv
package nvpr_pkg;

    // Service tracker states
    typedef enum logic {
        LV_IDLE,
        LV_SERVICE
    } lvl_state_t;

endpackage

// File: rtl/nvpr_mask_table.sv
// Builds the per-level masks of sources that outrank each level.
module nvpr_mask_table #(
    parameter int NUM_SLOTS = 16,
    parameter int SRC_W     = 32,
    parameter int SRC_IDX_W = $clog2(SRC_W),
    parameter int CTRL_W    = SRC_IDX_W + 1
) (
    input  logic [NUM_SLOTS-1:0][CTRL_W-1:0] ctrl,
    output logic [NUM_SLOTS+1:0][SRC_W-1:0]  masks
);
    localparam int EN_BIT = SRC_IDX_W;

    assign masks[0] = '0;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [SRC_W-1:0] claim;
        always_comb begin
            claim = '0;
            if (ctrl[s][EN_BIT]) begin
                claim[ctrl[s][SRC_IDX_W-1:0]] = 1'b1;
            end
        end
        assign masks[s+1] = masks[s] | claim;
    end

    // The idle level lets every source through
    assign masks[NUM_SLOTS+1] = '1;

endmodule

// File: rtl/nvpr_search.sv
// Finds the highest-priority level below the current one with a pending source.
module nvpr_search #(
    parameter int NUM_SLOTS = 16,
    parameter int SRC_W     = 32,
    parameter int LVL_W     = $clog2(NUM_SLOTS + 2)
) (
    input  logic [SRC_W-1:0]                 raw,
    input  logic [NUM_SLOTS+1:0][SRC_W-1:0]  masks,
    input  logic [LVL_W-1:0]                 cur_lvl,
    output logic                             found,
    output logic [LVL_W-1:0]                 found_idx
);
    always_comb begin
        found     = 1'b0;
        found_idx = '0;
        // Walk downward so the lowest qualifying level wins
        for (int i = NUM_SLOTS; i >= 0; i--) begin
            if ((LVL_W'(i) < cur_lvl) && (|(raw & masks[i+1]))) begin
                found     = 1'b1;
                found_idx = LVL_W'(i);
            end
        end
    end

endmodule

// File: rtl/nvpr_level_stack.sv
// Current service level plus one saved outer level per level.
module nvpr_level_stack
    import nvpr_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int LVL_W     = $clog2(NUM_SLOTS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic             unwind,
    input  logic             found,
    input  logic [LVL_W-1:0] found_idx,
    output logic [LVL_W-1:0] cur_lvl,
    output logic             in_service
);
    localparam int NUM_LVL = NUM_SLOTS + 1;
    localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(NUM_SLOTS + 1);

    lvl_state_t       state_q, state_d;
    logic [LVL_W-1:0] cur_q, cur_d;
    logic             save_en;
    logic [LVL_W-1:0] saved [NUM_LVL];
    logic [LVL_W-1:0] back_lvl;

    always_comb begin
        back_lvl = IDLE_LVL;
        if (cur_q < IDLE_LVL) begin
            back_lvl = saved[cur_q];
        end
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        save_en = 1'b0;
        unique case (state_q)
            LV_IDLE: begin
                if (ack && found) begin          // T_ENTER
                    save_en = 1'b1;
                    cur_d   = found_idx;
                    state_d = LV_SERVICE;
                end                              // else T_STAY
            end
            LV_SERVICE: begin
                if (ack && found) begin          // T_NEST
                    save_en = 1'b1;
                    cur_d   = found_idx;
                end else if (unwind) begin
                    cur_d   = back_lvl;
                    state_d = (back_lvl == IDLE_LVL) ? LV_IDLE      // T_RELEASE
                                                     : LV_SERVICE;  // T_UNWIND
                end                              // else T_STAY
            end
            default: begin
                state_d = LV_IDLE;
                cur_d   = IDLE_LVL;
            end
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LV_IDLE;
            cur_q   <= IDLE_LVL;
            for (int i = 0; i < NUM_LVL; i++) begin
                saved[i] <= IDLE_LVL;
            end
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            if (save_en) begin
                saved[found_idx] <= cur_q;
            end
        end
    end

    // Output process
    always_comb begin
        cur_lvl    = cur_q;
        in_service = (state_q == LV_SERVICE);
    end

    // R1: the state and the level agree on idle
    p_idle_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_IDLE) == (cur_q == IDLE_LVL));

    // R4: an acknowledge that finds a source moves to that level
    p_enter_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && found) |=> (cur_q == $past(found_idx)));

    // R7: a close in service always returns to an outer level
    p_unwind_outer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (unwind && !ack && state_q == LV_SERVICE) |=> (cur_q > $past(cur_q)));

    // R8: no strobe, no level change
    p_hold_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !unwind) |=> $stable(cur_q));

    // R7: a close at idle is ignored
    p_idle_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (unwind && state_q == LV_IDLE) |=> (cur_q == IDLE_LVL));

endmodule

// File: rtl/nvpr_core.sv
// Top level: register file, bus decode and the normal interrupt line.
module nvpr_core #(
    parameter int NUM_SLOTS = 16,
    parameter int SRC_W     = 32,
    parameter int DATA_W    = 32,
    parameter int WORD_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_raw,
    input  logic [SRC_W-1:0]  src_irq,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam int NUM_LVL   = NUM_SLOTS + 1;
    localparam int LVL_W     = $clog2(NUM_SLOTS + 2);
    localparam int SRC_IDX_W = $clog2(SRC_W);
    localparam int CTRL_W    = SRC_IDX_W + 1;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam logic [LVL_W-1:0]  IDLE_LVL   = LVL_W'(NUM_SLOTS + 1);
    localparam logic [WORD_W-1:0] W_VECT     = WORD_W'(12);
    localparam logic [WORD_W-1:0] W_DEFV     = WORD_W'(13);
    localparam logic [WORD_W-1:0] W_VA_BASE  = WORD_W'(64);
    localparam logic [WORD_W-1:0] W_VA_LAST  = WORD_W'(64 + NUM_SLOTS - 1);
    localparam logic [WORD_W-1:0] W_CT_BASE  = WORD_W'(128);
    localparam logic [WORD_W-1:0] W_CT_LAST  = WORD_W'(128 + NUM_SLOTS - 1);

    logic [NUM_LVL-1:0][DATA_W-1:0]     vaddr_q;
    logic [NUM_SLOTS-1:0][CTRL_W-1:0]   ctrl_q;
    logic [NUM_SLOTS+1:0][SRC_W-1:0]    masks;
    logic [LVL_W-1:0]                   cur_lvl;
    logic                               in_service;
    logic                               found;
    logic [LVL_W-1:0]                   found_idx;
    logic                               rd_stb, wr_stb, ack, unwind;
    logic                               hit_va, hit_ct;
    logic [WORD_W-1:0]                  va_off, ct_off;
    logic [SLOT_W-1:0]                  va_slot, ct_slot;
    logic [DATA_W-1:0]                  rd_next;

    // Bus decode
    assign rd_stb  = bus_sel && !bus_wr;
    assign wr_stb  = bus_sel && bus_wr;
    assign ack     = rd_stb && (bus_addr == W_VECT);
    assign unwind  = wr_stb && (bus_addr == W_VECT);
    assign hit_va  = (bus_addr >= W_VA_BASE) && (bus_addr <= W_VA_LAST);
    assign hit_ct  = (bus_addr >= W_CT_BASE) && (bus_addr <= W_CT_LAST);
    assign va_off  = bus_addr - W_VA_BASE;
    assign ct_off  = bus_addr - W_CT_BASE;
    assign va_slot = va_off[SLOT_W-1:0];
    assign ct_slot = ct_off[SLOT_W-1:0];

    // Register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_stb) begin
            if (hit_va) begin
                vaddr_q[va_slot] <= bus_wdata;
            end
            if (hit_ct) begin
                ctrl_q[ct_slot] <= bus_wdata[CTRL_W-1:0];
            end
            if (bus_addr == W_DEFV) begin
                vaddr_q[NUM_SLOTS] <= bus_wdata;
            end
        end
    end

    nvpr_mask_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .SRC_W     (SRC_W),
        .SRC_IDX_W (SRC_IDX_W),
        .CTRL_W    (CTRL_W)
    ) u_masks (
        .ctrl  (ctrl_q),
        .masks (masks)
    );

    nvpr_search #(
        .NUM_SLOTS (NUM_SLOTS),
        .SRC_W     (SRC_W),
        .LVL_W     (LVL_W)
    ) u_search (
        .raw       (src_raw),
        .masks     (masks),
        .cur_lvl   (cur_lvl),
        .found     (found),
        .found_idx (found_idx)
    );

    nvpr_level_stack #(
        .NUM_SLOTS (NUM_SLOTS),
        .LVL_W     (LVL_W)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack        (ack),
        .unwind     (unwind),
        .found      (found),
        .found_idx  (found_idx),
        .cur_lvl    (cur_lvl),
        .in_service (in_service)
    );

    // Read data selection
    always_comb begin
        rd_next = '0;
        if (bus_addr == W_VECT) begin
            if (found) begin
                rd_next = vaddr_q[found_idx];
            end else if (cur_lvl == IDLE_LVL) begin
                rd_next = vaddr_q[NUM_SLOTS];
            end else begin
                rd_next = vaddr_q[cur_lvl];
            end
        end else if (bus_addr == W_DEFV) begin
            rd_next = vaddr_q[NUM_SLOTS];
        end else if (hit_va) begin
            rd_next = vaddr_q[va_slot];
        end else if (hit_ct) begin
            rd_next = DATA_W'(ctrl_q[ct_slot]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_stb) begin
            bus_rdata <= rd_next;
        end
    end

    assign irq_out = |(src_irq & masks[cur_lvl]);

    // R6: a found level is always above the current one
    p_found_higher_r6: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (found_idx < cur_lvl));

    // R3: the line never rises without a routed source
    p_irq_needs_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|src_irq));

    // R8: read data holds between reads
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(bus_rdata));

    // R1: the in-service flag matches the level
    p_service_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_service == (cur_lvl != IDLE_LVL));

endmodule

// File: tb/nvpr_core_test.sv
`timescale 1ns/1ps
module nvpr_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_raw = '0;
    logic [31:0] src_irq = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [9:0] VECT = 10'd12;
    localparam logic [9:0] DEFV = 10'd13;
    localparam logic [9:0] VA0  = 10'd64;
    localparam logic [9:0] CT0  = 10'd128;

    always #2.5 clk = ~clk;

    nvpr_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_raw   (src_raw),
        .src_irq   (src_irq),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    // Drive src_irq and sample the combinational line shortly after
    task automatic irq_chk(input string req, input logic [31:0] pend, input logic exp);
        src_irq = pend;
        #1;
        chk(req, {31'd0, irq_out}, {31'd0, exp});
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        rd(VA0, d);        chk("R1 slot 0 address", d, 32'h0);
        rd(VA0 + 10'd15, d); chk("R1 slot 15 address", d, 32'h0);
        rd(CT0 + 10'd3, d); chk("R1 control byte 3", d, 32'h0);
        rd(DEFV, d);       chk("R1 default address", d, 32'h0);
        irq_chk("R1 idle passes any source", 32'h8000_0000, 1'b1);
        irq_chk("R3 no source no line", 32'h0, 1'b0);
    endtask

    task automatic t_program;
        logic [31:0] d;
        wr(CT0, 32'hE3);              // bits 7:6 dropped
        wr(CT0 + 10'd1, 32'h27);
        wr(CT0 + 10'd2, 32'h05);      // disabled, source 5
        wr(VA0, 32'h1000);
        wr(VA0 + 10'd1, 32'h1100);
        wr(VA0 + 10'd2, 32'h1200);
        wr(DEFV, 32'hDEF0);
        rd(CT0, d);        chk("R2 upper control bits dropped", d, 32'h23);
        rd(CT0 + 10'd2, d); chk("R2 disabled control readback", d, 32'h05);
        rd(VA0 + 10'd1, d); chk("R2 slot 1 address readback", d, 32'h1100);
        rd(DEFV, d);       chk("R10 default address readback", d, 32'hDEF0);
    endtask

    task automatic t_nesting;
        logic [31:0] d;
        src_raw = 32'h80;              // source 7 -> slot 1
        rd(VECT, d);       chk("R4 acknowledge slot 1", d, 32'h1100);
        irq_chk("R3 level 1 masks source 7", 32'h80, 1'b0);
        irq_chk("R3 level 1 passes source 3", 32'h08, 1'b1);
        rd(VECT, d);       chk("R6 same level read returns current", d, 32'h1100);
        irq_chk("R6 level unchanged after same-level read", 32'h08, 1'b1);
        src_raw = 32'h88;
        rd(VECT, d);       chk("R6 nest into slot 0", d, 32'h1000);
        irq_chk("R3 level 0 masks everything", 32'h88, 1'b0);
        rd(VECT, d);       chk("R6 nothing above slot 0", d, 32'h1000);
        wr(VECT, 32'h0);
        irq_chk("R7 back to level 1 passes source 3", 32'h08, 1'b1);
        irq_chk("R7 back to level 1 masks source 7", 32'h80, 1'b0);
        wr(VECT, 32'h0);
        irq_chk("R7 back to idle", 32'h80, 1'b1);
        wr(VECT, 32'h0);
        irq_chk("R7 close at idle ignored", 32'h80, 1'b1);
        src_raw = 32'h0;
    endtask

    task automatic t_default;
        logic [31:0] d;
        src_raw = 32'h20;              // source 5 claimed by no enabled slot
        rd(VECT, d);       chk("R5 unclaimed source gives default", d, 32'hDEF0);
        irq_chk("R5 level 16 masks source 5", 32'h20, 1'b0);
        irq_chk("R3 level 16 passes source 7", 32'h80, 1'b1);
        wr(VECT, 32'h0);
        irq_chk("R7 release from level 16", 32'h20, 1'b1);
        src_raw = 32'h0;
        rd(VECT, d);       chk("R5 nothing pending gives default", d, 32'hDEF0);
        irq_chk("R5 level stays idle", 32'h20, 1'b1);
    endtask

    task automatic t_held;
        logic [31:0] d;
        src_raw = 32'h88;              // both slots pending
        rd(VECT, d);       chk("R4 lowest slot wins", d, 32'h1000);
        src_raw = 32'h80;
        repeat (4) @(negedge clk);
        chk("R8 read data held", bus_rdata, 32'h1000);
        irq_chk("R8 single entry only", 32'h08, 1'b0);
        wr(VECT, 32'h0);
        irq_chk("R8 one close reaches idle", 32'h100, 1'b1);
        src_raw = 32'h0;
    endtask

    task automatic t_ctrl_change;
        logic [31:0] d;
        src_raw = 32'h80;
        rd(VECT, d);       chk("R4 enter slot 1 again", d, 32'h1100);
        wr(CT0, 32'h29);               // slot 0 now claims source 9
        irq_chk("R9 new source outranks at once", 32'h200, 1'b1);
        irq_chk("R9 old source no longer outranks", 32'h08, 1'b0);
        wr(VECT, 32'h0);
        src_raw = 32'h0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_nesting();
        t_default();
        t_held();
        t_ctrl_change();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            #100000;
        join_any
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule